// File: doc/BRIEF.md
# Daisy-Chained Converter Readback Controller

This block is the host side of a three-wire link to a chain of identical 16-bit successive-approximation converters wired in series: the serial output of each converter feeds the serial input of the next, and the converter nearest the host drives the host's data input. On a start request the controller raises the convert strobe while the serial clock sits low. It waits a fixed number of system clocks for the conversion to finish and then clocks the whole chain like one long shift register. It captures the returned data on each falling serial clock edge.

When the last bit is in, the captured stream is split into one word per converter. The words are handed out one at a time on a valid/ready stream, each tagged with a device index and a last flag. The convert strobe drops only after the final word has been accepted. The serial clock phase length, the conversion wait, the chain length and the word width are parameters. The total read time grows with the chain length, so longer chains lower the achievable sample rate.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is asserted, and after it, `cnv_o`, `sck_o`, `word_valid_o` and `sdi_o` are all 0.
- R2: A `start_i` sampled high while idle makes `cnv_o` high in the following cycle, and `sck_o` is 0 whenever `cnv_o` rises.
- R3: The first rising edge of `sck_o` comes exactly CONV_WAIT + SCK_HALF system clocks after the rising edge of `cnv_o`.
- R4: One read produces exactly 16 × NUM_DEV pulses on `sck_o`, each high for SCK_HALF clocks, with a rise-to-rise period of 2 × SCK_HALF clocks. `sck_o` returns to 0 after the last pulse.
- R5: `cnv_o` stays high from the start of a read until the last word is accepted, and goes low in the cycle after that handshake.
- R6: `sdo_i` is sampled once per falling `sck_o` edge. Word k (k = 0 is the first word sent, tagged `word_dev_o` = k) holds the serial bits k×16 to k×16+15 in order, the first of them in bit 15. `word_last_o` is 1 only on word NUM_DEV−1.
- R7: While `word_valid_o` is high and `word_ready_i` is low, the valid flag, data, index and last flag all hold.
- R8: `start_i` is ignored from the start of a read until `cnv_o` has returned low. No extra serial clocks and no second `cnv_o` rise result from it.
- R9: `sdi_o` is always 0, so that zeros shift in behind the valid chain data.
- R10: `sck_o` is never high while `cnv_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readback |
| sdo_i | input | 1 | Serial data from the nearest converter |
| cnv_o | output | 1 | Convert strobe, high for the whole read |
| sck_o | output | 1 | Serial clock, idles low |
| sdi_o | output | 1 | Serial input of the far-end converter, held low |
| word_valid_o | output | 1 | Output word available |
| word_ready_i | input | 1 | Consumer accepts the word |
| word_data_o | output | WORD_W | Word of one converter |
| word_dev_o | output | DEV_W | Position of the converter in the chain, 0 nearest the host |
| word_last_o | output | 1 | Marks the word of the last converter |

## Verification
The assertions assume that the converter chain changes `sdo_i` only after a falling serial clock edge. They also assume that `rst_n` is held low long enough to clear the block, and that the consumer may hold `word_ready_i` low for any number of cycles. The bench models the chain as a stream that advances on each falling edge of `sck_o`, and it drives `start_i` and `word_ready_i` only at falling system clock edges. Stalls, repeated start pulses during a read, and a reset in the middle of a read are all applied within those limits.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_EMIT  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/chain_sck_gen.sv
module chain_sck_gen #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int PH_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            sck_q, sck_d;
  logic            tick;

  assign tick = run_i && (ph_q == PH_W'(SCK_HALF - 1));

  always_comb begin
    ph_d  = ph_q;
    sck_d = sck_q;
    if (!run_i) begin
      ph_d  = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      ph_d  = '0;
      sck_d = ~sck_q;
    end else begin
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = tick && sck_q;
endmodule

// File: rtl/chain_capture.sv
module chain_capture #(
  parameter int TOTAL_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  shift_i,
  input  logic                  sdo_i,
  output logic [TOTAL_BITS-1:0] data_o,
  output logic                  last_bit_o
);
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [TOTAL_BITS-1:0] sr_q, sr_d;
  logic                  sr_en;

  assign sr_en = shift_i;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (sr_en) begin
      cnt_d = cnt_q + 1'b1;
      sr_d  = {sr_q[TOTAL_BITS-2:0], sdo_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  assign data_o     = sr_q;
  assign last_bit_o = shift_i && (cnt_q == CNT_W'(TOTAL_BITS - 1));
endmodule

// File: rtl/chain_word_emit.sv
module chain_word_emit #(
  parameter int NUM_DEV = 4,
  parameter int WORD_W  = 16,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      active_i,
  input  logic [NUM_DEV*WORD_W-1:0] buf_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [WORD_W-1:0]         data_o,
  output logic [DEV_W-1:0]          dev_o,
  output logic                      last_o,
  output logic                      done_o
);
  logic [DEV_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] words [NUM_DEV];
  logic              is_last;
  logic              take;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_slice
    assign words[g] = buf_i[(NUM_DEV-g)*WORD_W-1 -: WORD_W];
  end

  assign is_last = (idx_q == DEV_W'(NUM_DEV - 1));
  assign take    = active_i && ready_i;

  always_comb begin
    idx_d = idx_q;
    if (clear_i) begin
      idx_d = '0;
    end else if (take && !is_last) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign valid_o = active_i;
  assign data_o  = words[idx_q];
  assign dev_o   = idx_q;
  assign last_o  = active_i && is_last;
  assign done_o  = take && is_last;
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_adc_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int WORD_W    = 16,
  parameter int SCK_HALF  = 2,
  parameter int CONV_WAIT = 20,
  localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic [DEV_W-1:0]  word_dev_o,
  output logic              word_last_o
);
  localparam int TOTAL_BITS = NUM_DEV * WORD_W;
  localparam int CW_W       = $clog2(CONV_WAIT + 1);

  // reset: asserts at once, releases on clk
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rd_state_e        state_q, state_d;
  logic [CW_W-1:0]  wait_q, wait_d;
  logic             cnv_q, cnv_d;
  logic             accept;
  logic             sck_fall;
  logic             last_bit;
  logic             emit_done;
  logic [TOTAL_BITS-1:0] cap_data;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: begin
        wait_d = '0;
        if (start_i) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (wait_q == CW_W'(CONV_WAIT - 1)) state_d = ST_SHIFT;
        else                                wait_d  = wait_q + 1'b1;
      end
      ST_SHIFT: begin
        if (last_bit) state_d = ST_EMIT;
      end
      ST_EMIT: begin
        if (emit_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    cnv_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      cnv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      cnv_q   <= cnv_d;
    end
  end

  chain_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (state_q == ST_SHIFT),
    .sck_o  (sck_o),
    .fall_o (sck_fall)
  );

  chain_capture #(.TOTAL_BITS(TOTAL_BITS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (accept),
    .shift_i    (sck_fall),
    .sdo_i      (sdo_i),
    .data_o     (cap_data),
    .last_bit_o (last_bit)
  );

  chain_word_emit #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (accept),
    .active_i (state_q == ST_EMIT),
    .buf_i    (cap_data),
    .ready_i  (word_ready_i),
    .valid_o  (word_valid_o),
    .data_o   (word_data_o),
    .dev_o    (word_dev_o),
    .last_o   (word_last_o),
    .done_o   (emit_done)
  );

  assign cnv_o = cnv_q;
  assign sdi_o = 1'b0;
endmodule

// File: rtl/chain_adc_checker.sv
module chain_adc_checker #(
  parameter int NUM_DEV  = 4,
  parameter int WORD_W   = 16,
  parameter int SCK_HALF = 2,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_o,
  input logic              sck_o,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [WORD_W-1:0] word_data_o,
  input logic [DEV_W-1:0]  word_dev_o,
  input logic              word_last_o
);
  logic [15:0] hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len_q <= '0;
    else if (sck_o) hi_len_q <= hi_len_q + 1'b1;
    else            hi_len_q <= '0;
  end

  assert_cnv_rise_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !sck_o);

  assert_sck_high_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> hi_len_q == 16'(SCK_HALF));

  assert_cnv_fall_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> $past(word_valid_o && word_ready_i && word_last_o));

  assert_valid_inside_cnv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> cnv_o);

  assert_last_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_last_o) |-> word_dev_o == DEV_W'(NUM_DEV - 1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_dev_o) && $stable(word_last_o)));

  assert_sck_needs_cnv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> cnv_o);
endmodule

bind chain_adc_reader chain_adc_checker #(
  .NUM_DEV (NUM_DEV),
  .WORD_W  (WORD_W),
  .SCK_HALF(SCK_HALF)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnv_o        (cnv_o),
  .sck_o        (sck_o),
  .word_valid_o (word_valid_o),
  .word_ready_i (word_ready_i),
  .word_data_o  (word_data_o),
  .word_dev_o   (word_dev_o),
  .word_last_o  (word_last_o)
);

// File: tb/tb_chain_adc_reader.sv
module tb_chain_adc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int W   = 16;
  localparam int SH  = 2;
  localparam int CW  = 20;
  localparam int TOT = N * W;
  localparam int NV  = 6;

  localparam logic [TOT-1:0] VEC_DATA [NV] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'hAAAA_5555_AAAA_5555,
    64'h1234_5678_9ABC_DEF0,
    64'h8001_0000_7FFE_C3A5,
    64'h0F0F_F0F0_00FF_FF00
  };
  localparam int VEC_STALL [NV] = '{0, 0, 3, 1, 5, 2};

  logic clk, rst_n, start_i, sdo_i, word_ready_i;
  logic cnv_o, sck_o, sdi_o, word_valid_o, word_last_o;
  logic [W-1:0] word_data_o;
  logic [1:0]   word_dev_o;

  int checks = 0;
  int failures = 0;

  chain_adc_reader #(.NUM_DEV(N), .WORD_W(W), .SCK_HALF(SH), .CONV_WAIT(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o),
    .word_valid_o(word_valid_o), .word_ready_i(word_ready_i),
    .word_data_o(word_data_o), .word_dev_o(word_dev_o), .word_last_o(word_last_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // converter chain model: MSB of the nearest device first, zeros behind
  logic [TOT-1:0] stream;
  int bit_idx;
  assign sdo_i = (bit_idx < TOT) ? stream[TOT-1-bit_idx] : 1'b0;
  always @(negedge sck_o) bit_idx <= bit_idx + 1;

  int cyc = 0;
  int t_cnv, t_sck1, t_sck2, sck_rises, cnv_rises;
  always @(posedge clk) cyc++;
  always @(posedge cnv_o) begin
    t_cnv = cyc;
    cnv_rises++;
  end
  always @(posedge sck_o) begin
    if (sck_rises == 0) t_sck1 = cyc;
    if (sck_rises == 1) t_sck2 = cyc;
    sck_rises++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [TOT-1:0] d);
    stream    = d;
    bit_idx   = 0;
    sck_rises = 0;
    cnv_rises = 0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000 && !word_valid_o; i++) @(negedge clk);
  endtask

  // full read with optional stalls and stray start pulses
  task automatic do_read(input logic [TOT-1:0] d, input int stall, input bit poke);
    logic [W-1:0] held;
    arm(d);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R2 cnv high after start", cnv_o, 1'b1);
    if (poke) begin
      repeat (CW + 10) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    for (int w = 0; w < N; w++) begin
      wait_valid();
      held = word_data_o;
      if (poke && w == 1) begin
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R7 valid held", word_valid_o, 1'b1);
        chk("R7 data held", word_data_o, held);
      end
      chk("R6 word data", word_data_o, d[(N-w)*W-1 -: W]);
      chk("R6 device index", word_dev_o, w[1:0]);
      chk("R6 last flag", word_last_o, (w == N-1));
      chk("R5 cnv high during output", cnv_o, 1'b1);
      chk("R9 sdi low", sdi_o, 1'b0);
      word_ready_i = 1'b1;
      @(negedge clk) word_ready_i = 1'b0;
    end
    chk("R5 cnv low after last word", cnv_o, 1'b0);
    chk("R4 sck pulse count", sck_rises, TOT);
    chk("R4 sck period", t_sck2 - t_sck1, 2*SH);
    chk("R3 conversion wait", t_sck1 - t_cnv, CW + SH);
    chk("R10 sck idle low", sck_o, 1'b0);
    chk("R8 single cnv rise", cnv_rises, 1);
    chk("R1 valid low after read", word_valid_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; word_ready_i = 1'b0;
    arm('0);
    repeat (3) @(negedge clk);
    chk("R1 cnv in reset", cnv_o, 1'b0);
    chk("R1 sck in reset", sck_o, 1'b0);
    chk("R1 valid in reset", word_valid_o, 1'b0);
    chk("R9 sdi in reset", sdi_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cnv after reset", cnv_o, 1'b0);
    chk("R1 valid after reset", word_valid_o, 1'b0);

    // table of patterns and stall lengths
    for (int v = 0; v < NV; v++) do_read(VEC_DATA[v], VEC_STALL[v], 1'b0);

    // R8: start pulses during conversion wait, shift and output are ignored
    do_read(64'hC0DE_BEEF_1357_2468, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 no stray read", cnv_o, 1'b0);

    // R1: reset in the middle of shifting, then a clean read
    arm(64'h5A5A_A5A5_3C3C_C3C3);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (CW + 40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 cnv cleared by reset", cnv_o, 1'b0);
    chk("R1 sck cleared by reset", sck_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after mid reset", word_valid_o, 1'b0);
    do_read(64'h0001_8000_FFFE_7FFF, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule